// File: doc/BRIEF.md
# Real-mode segmented address generator

This block turns a segment:offset pair into a physical byte address in the manner of a 16-bit real-mode processor. It keeps four 16-bit segment registers, loaded through a simple write port. Each request names one of the four registers and carries a 16-bit offset. The block shifts the segment value left by four bits to form a base on a 16-byte boundary. It adds the zero-extended offset to that base, and one cycle later it presents the result together with an overflow flag.

The control input `a20_en` decides what happens when the sum passes the top of the 1 MiB space. When it is low, bit 20 is forced to zero, so the address wraps back into low memory. When it is high, bit 20 carries the adder's carry-out, so the address can reach just above 1 MiB, up to 10FFEFh. The block enforces no segment limit and raises no fault. Every offset is legal with every segment.

Top module: `seg_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears all four segment registers to 0000h, drives `out_valid` low, and sets `out_addr` and `out_ovf` to zero in the cycle after it is sampled.
- R2: For a request, the untruncated sum is (segment << 4) + zero-extended offset. For example, 06EFh:1234h, 0812h:0004h and 0000h:8124h all give 08124h, and 000Ch:000Fh gives 000CFh. Every offset from 0000h to FFFFh is accepted with every segment value.
- R3: With `a20_en` low, `out_addr[20]` is 0 and `out_addr[19:0]` is the sum modulo 2^20. For example, FFFFh:0010h gives 00000h and FFFDh:03E8h gives 003B8h.
- R4: With `a20_en` high, `out_addr` carries the full 21-bit sum. For example, FFFFh:0010h gives 100000h and FFFFh:FFFFh gives 10FFEFh.
- R5: `out_ovf` is 1 exactly when the untruncated sum is 100000h or more, whatever the value of `a20_en`. An offset of 0000h never sets it.
- R6: `out_valid` equals the `req_valid` of the previous cycle. `out_addr` and `out_ovf` are updated only on a cycle after a request and otherwise keep their value.
- R7: When `wr_en` is high, segment register `wr_idx` is loaded with `wr_val`. The index encoding is 0 = code, 1 = data, 2 = stack, 3 = extra. A request that selects the same register in the same cycle as the write uses the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load a segment register |
| wr_idx | input | 2 | Register to load (0 code, 1 data, 2 stack, 3 extra) |
| wr_val | input | 16 | New segment value |
| req_valid | input | 1 | Address request this cycle |
| req_sel | input | 2 | Segment register used by the request |
| req_off | input | 16 | Offset within the segment |
| a20_en | input | 1 | 1 keeps the carry as bit 20, 0 wraps at 1 MiB |
| out_valid | output | 1 | Result from the previous cycle's request is present |
| out_addr | output | 21 | Physical address |
| out_ovf | output | 1 | Sum reached 100000h or more |

## Verification
The hardest case to reach from the ports is a write to a register and a read of that same register in the same cycle. Only in that cycle can the old-value rule be seen. The stimulus first loads a known segment. It then raises `wr_en` and `req_valid` together with the same index, checks that the result is built from the old segment, and issues a second request to confirm that the new value took effect. The wrap boundary is reached by loading segments near FFFFh and pairing them with offsets on either side of the 1 MiB crossing, once with `a20_en` low and once with it high.

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int NSEG  = 4,
  localparam int IDX_W  = $clog2(NSEG),
  localparam int BASE_W = SEG_W + SHIFT,
  localparam int SUM_W  = BASE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_val,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_sel,
  input  logic [OFF_W-1:0] req_off,
  input  logic             a20_en,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_addr,
  output logic             out_ovf
);

  logic [SEG_W-1:0] seg_q [NSEG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSEG; i++) seg_q[i] <= '0;
    end else if (wr_en) begin
      seg_q[wr_idx] <= wr_val;
    end
  end

  wire [BASE_W-1:0] base = {seg_q[req_sel], {SHIFT{1'b0}}};
  wire [SUM_W-1:0]  sum  = {1'b0, base} + {{(SUM_W-OFF_W){1'b0}}, req_off};
  wire              cry  = sum[SUM_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_ovf   <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_addr <= {cry & a20_en, sum[BASE_W-1:0]};
        out_ovf  <= cry;
      end
    end
  end

endmodule

module seg_addr_gen_chk #(
  parameter int IDX_W = 2,
  parameter int OFF_W = 16,
  parameter int SUM_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic [OFF_W-1:0] req_off,
  input logic             a20_en,
  input logic             out_valid,
  input logic [SUM_W-1:0] out_addr,
  input logic             out_ovf
);

  p_reset_clear_r1: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_addr == '0 && !out_ovf));

  p_wrap_top_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !a20_en) |=> !out_addr[SUM_W-1]);

  p_a20_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && a20_en) |=> (out_addr[SUM_W-1] == out_ovf));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_off == '0) |=> !out_ovf);

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!out_valid && $stable(out_addr) && $stable(out_ovf)));

endmodule

bind seg_addr_gen seg_addr_gen_chk #(
  .IDX_W(IDX_W), .OFF_W(OFF_W), .SUM_W(SUM_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_off(req_off),
  .a20_en(a20_en), .out_valid(out_valid), .out_addr(out_addr), .out_ovf(out_ovf)
);

// File: tb/sim_seg_addr_gen.sv
module sim_seg_addr_gen;

  logic        clk = 1'b0;
  logic        rst, wr_en, req_valid, a20_en;
  logic [1:0]  wr_idx, req_sel;
  logic [15:0] wr_val, req_off;
  logic        out_valid, out_ovf;
  logic [20:0] out_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  seg_addr_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .req_valid(req_valid), .req_sel(req_sel), .req_off(req_off), .a20_en(a20_en),
    .out_valid(out_valid), .out_addr(out_addr), .out_ovf(out_ovf)
  );

  // seg, off, a20, expected addr, expected ovf
  localparam int NV = 14;
  localparam logic [54:0] VEC [NV] = '{
    {16'h06EF, 16'h1234, 1'b0, 21'h008124, 1'b0},
    {16'h0812, 16'h0004, 1'b1, 21'h008124, 1'b0},
    {16'h0000, 16'h8124, 1'b0, 21'h008124, 1'b0},
    {16'h000C, 16'h000F, 1'b0, 21'h0000CF, 1'b0},
    {16'hFFFF, 16'h0010, 1'b0, 21'h000000, 1'b1},
    {16'hFFFD, 16'h03E8, 1'b0, 21'h0003B8, 1'b1},
    {16'hFFFF, 16'h0010, 1'b1, 21'h100000, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 21'h10FFEF, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 21'h00FFEF, 1'b1},
    {16'hF000, 16'hFFFF, 1'b1, 21'h0FFFFF, 1'b0},
    {16'hFFFF, 16'h000F, 1'b1, 21'h0FFFFF, 1'b0},
    {16'h1234, 16'h0000, 1'b1, 21'h012340, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 21'h088000, 1'b0},
    {16'hFFFF, 16'h0000, 1'b1, 21'h0FFFF0, 1'b0}
  };

  task automatic check(input string req, input logic [20:0] got_a, input logic got_o,
                       input logic got_v, input logic [20:0] exp_a, input logic exp_o,
                       input logic exp_v);
    checks++;
    if (got_a !== exp_a || got_o !== exp_o || got_v !== exp_v) begin
      fails++;
      $display("FAIL %s: addr=%h ovf=%b valid=%b expected addr=%h ovf=%b valid=%b",
               req, got_a, got_o, got_v, exp_a, exp_o, exp_v);
    end
  endtask

  task automatic idle();
    wr_en = 0; req_valid = 0;
    @(negedge clk);
  endtask

  task automatic load(input logic [1:0] idx, input logic [15:0] v);
    wr_en = 1; wr_idx = idx; wr_val = v; req_valid = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic request(input logic [1:0] sel, input logic [15:0] off, input logic a20);
    req_valid = 1; req_sel = sel; req_off = off; a20_en = a20;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        checks++; fails++;
        $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [20:0] held_a;
    logic        held_o;
    rst = 1; wr_en = 0; req_valid = 0; wr_idx = 0; req_sel = 0;
    wr_val = 0; req_off = 0; a20_en = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check("R1 reset outputs", out_addr, out_ovf, out_valid, 21'h0, 1'b0, 1'b0);

    // R1: registers cleared, each reads as zero
    for (int s = 0; s < 4; s++) begin
      request(2'(s), 16'h0010, 1'b1);
      check("R1 reset segment", out_addr, out_ovf, out_valid, 21'h000010, 1'b0, 1'b1);
    end

    // R2 R3 R4 R5 vector walk, rotating over all registers (R7)
    for (int i = 0; i < NV; i++) begin
      logic [1:0] idx = 2'(i);
      load(idx, VEC[i][54:39]);
      request(idx, VEC[i][38:23], VEC[i][22]);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), out_addr, out_ovf, out_valid,
            VEC[i][21:1], VEC[i][0], 1'b1);
    end

    // R6: idle cycle keeps address, drops valid
    held_a = out_addr; held_o = out_ovf;
    idle();
    check("R6 idle hold", out_addr, out_ovf, out_valid, held_a, held_o, 1'b0);

    // R7: distinct values in all four registers
    load(2'd0, 16'h1000); load(2'd1, 16'h2000); load(2'd2, 16'h3000); load(2'd3, 16'h4000);
    for (int s = 0; s < 4; s++) begin
      request(2'(s), 16'h0001, 1'b0);
      check("R7 register select", out_addr, out_ovf, out_valid,
            21'((s + 1) * 21'h10000 + 1), 1'b0, 1'b1);
    end

    // R7: write and read of same register in one cycle returns old value
    wr_en = 1; wr_idx = 2'd1; wr_val = 16'h5000;
    req_valid = 1; req_sel = 2'd1; req_off = 16'h0000; a20_en = 0;
    @(negedge clk);
    wr_en = 0; req_valid = 0;
    check("R7 same-cycle old value", out_addr, out_ovf, out_valid, 21'h020000, 1'b0, 1'b1);
    request(2'd1, 16'h0000, 1'b0);
    check("R7 new value after write", out_addr, out_ovf, out_valid, 21'h050000, 1'b0, 1'b1);

    // R1: reset mid-run clears the registers again
    rst = 1;
    @(negedge clk);
    rst = 0;
    check("R1 second reset outputs", out_addr, out_ovf, out_valid, 21'h0, 1'b0, 1'b0);
    request(2'd3, 16'hFFFF, 1'b1);
    check("R1 second reset segment", out_addr, out_ovf, out_valid, 21'h00FFFF, 1'b0, 1'b1);

    // R6: back-to-back requests each land one cycle later
    load(2'd2, 16'hFFFF);
    req_valid = 1; req_sel = 2'd2; req_off = 16'h0010; a20_en = 1;
    @(negedge clk);
    check("R6 back-to-back first", out_addr, out_ovf, out_valid, 21'h100000, 1'b1, 1'b1);
    a20_en = 0;
    @(negedge clk);
    req_valid = 0;
    check("R6 back-to-back second", out_addr, out_ovf, out_valid, 21'h000000, 1'b1, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule